// File: doc/BRIEF.md
# PLL Phase-Step Sequencer

This block sits on the user side of a PLL that can shift the phase of its output clocks one small increment at a time. It runs in the PLL's scan clock domain. A requester hands it one command through a valid/ready handshake. The command carries three things: which output counter to move, which direction to move it, and how many increments to apply. The sequencer then runs the PLL's step handshake once for each increment. It raises the step strobe, holds it until the PLL's done flag has dropped, releases it, and waits for done to come back high before it starts the next step.

The done flag arrives asynchronously, so it passes through a synchroniser before the control logic uses it. Every timing rule is counted in scan clock cycles after synchronisation. If done never falls, a watchdog ends the command and flags an error. An abort request lets the step already in flight finish its handshake and then stops. A counter reports how many steps have completed. A one-cycle finish pulse tells the requester that the command has ended.

Top module: `phase_step_seq`

## Requirements
- R1: `cmd_ready` is high exactly while the sequencer is idle. A `cmd_valid` seen while busy is ignored and does not change the select, the direction, the step count or the number of pulses.
- R2: `pll_sel` and `pll_updn` take the command's values at acceptance, one cycle or more before the first strobe. They hold those values stable until the command finishes.
- R3: The step strobe `pll_step` rises only when the synchronised done flag is high. This applies to the first step and to every later one.
- R4: Each strobe pulse stays high for at least MIN_HOLD (default 2) scan clock cycles.
- R5: A strobe pulse is released only after done has been seen low during that pulse. This holds even when done has already returned high before the minimum hold time has passed.
- R6: After a release the strobe stays low for at least one cycle. The next pulse waits until done is high again.
- R7: A command of N steps (N from 1 to 1023, 10-bit field) produces exactly N strobe pulses. `steps_done` counts completed pulses, is cleared on acceptance, and ends at N.
- R8: A command with a step count of zero raises `cmd_finish` in the cycle after acceptance. It produces no strobe, and `busy` never rises.
- R9: If done does not fall while the strobe is high, the strobe drops after exactly TIMEOUT (default 64) high cycles. `err_timeout` then rises and stays high until the next command is accepted, `cmd_finish` pulses, and the step is not counted.
- R10: While busy, `abort` lets any pulse already in progress complete its full handshake, including the return of done. No further pulses follow, and `cmd_finish` pulses. An abort in the cycle after acceptance ends the command with no pulse. An abort while idle has no effect.
- R11: `cmd_finish` is a single-cycle pulse. `busy` is low and `cmd_ready` is high in the cycle where it is seen.
- R12: After reset the block is idle and ready, with strobe, busy, finish, error and step count all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_sel | input | SEL_W | Output counter to shift |
| cmd_up | input | 1 | Direction: 1 shifts up, 0 shifts down |
| cmd_steps | input | CNT_W | Number of phase increments |
| abort | input | 1 | Stop after the step in flight |
| pll_done | input | 1 | Done flag from the PLL, asynchronous |
| pll_step | output | 1 | Step strobe to the PLL |
| pll_updn | output | 1 | Direction to the PLL |
| pll_sel | output | SEL_W | Counter select to the PLL |
| busy | output | 1 | Command in progress |
| cmd_finish | output | 1 | One-cycle pulse when a command ends |
| err_timeout | output | 1 | Last command ended because done never fell |
| steps_done | output | CNT_W | Steps completed in the current or last command |

## Verification
The hardest case to reach is a done flag whose low time is shorter than the minimum strobe hold. In that case done has already returned high when the strobe may be released, so the sequencer must rely on its memory of having seen done low. The bench's PLL model picks a random reaction delay and a random low time for every pulse, down to a single cycle, so this case comes up many times in each random command. Directed runs cover the rest: a model that never drops done (timeout), aborts in the first cycle and during a pulse, a command offered while busy, a zero count, and the full 1023-step count.

// File: rtl/phase_seq_pkg.sv
// Shared types for the phase-step sequencer.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package phase_seq_pkg;

    // Sequencer phases: idle, select settling, strobe high, strobe low awaiting done
    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_SETUP   = 2'd1,
        SQ_PULSE   = 2'd2,
        SQ_RECOVER = 2'd3
    } seq_state_t;

endpackage

// File: rtl/seq_sync.sv
// Multi-stage synchroniser for one asynchronous level.
// Assumes: the input is a slow level (many cycles wide) so single-bit
// synchronisation is enough; reset value chosen by parameter.
module seq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RESET_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/strobe_timer.sv
// Counts cycles the strobe has been high; flags minimum-hold reached and
// the watchdog limit reached.
// Assumes: run is high for the whole pulse and low between pulses;
// TIMEOUT > MIN_HOLD >= 1.
module strobe_timer #(
    parameter int MIN_HOLD = 2,
    parameter int TIMEOUT  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hold_met,
    output logic expired
);

    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);
    localparam logic [TW-1:0] HOLD = TW'(MIN_HOLD - 1);

    logic [TW-1:0] cnt;

    // Saturating count of high cycles, cleared while the strobe is low
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign hold_met = (cnt >= HOLD);
    assign expired  = (cnt >= LAST);

    // R9: the counter never runs past the watchdog limit
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R4: while running, the count advances by one until it saturates
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(rst_n) && ($past(cnt) != LAST)) |-> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/seq_ctrl.sv
// Command and handshake state machine of the phase-step sequencer.
// Assumes: done_s is already synchronised to clk; hold_met/expired come
// from a timer that runs exactly while the state is SQ_PULSE.
module seq_ctrl
    import phase_seq_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [SEL_W-1:0] cmd_sel,
    input  logic             cmd_up,
    input  logic [CNT_W-1:0] cmd_steps,
    input  logic             abort,
    input  logic             done_s,
    input  logic             hold_met,
    input  logic             expired,
    output seq_state_t       state,
    output logic [SEL_W-1:0] sel_q,
    output logic             up_q,
    output logic [CNT_W-1:0] steps_done,
    output logic             err,
    output logic             finish
);

    logic [CNT_W-1:0] remaining;
    logic             seen_low;
    logic             abort_pend;
    logic             release_ok;
    logic             time_out;

    // Release needs the hold time and a low done seen in this pulse
    assign release_ok = hold_met && (seen_low || !done_s);
    // Watchdog fires only if done was never seen low
    assign time_out   = expired && done_s && !seen_low;

    // Main sequencing: accept, settle, pulse, recover, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            sel_q      <= '0;
            up_q       <= 1'b0;
            remaining  <= '0;
            steps_done <= '0;
            err        <= 1'b0;
            finish     <= 1'b0;
            seen_low   <= 1'b0;
            abort_pend <= 1'b0;
        end else begin
            finish <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (cmd_valid) begin
                        err        <= 1'b0;
                        steps_done <= '0;
                        abort_pend <= 1'b0;
                        if (cmd_steps == '0) begin
                            finish <= 1'b1;
                        end else begin
                            sel_q     <= cmd_sel;
                            up_q      <= cmd_up;
                            remaining <= cmd_steps;
                            state     <= SQ_SETUP;
                        end
                    end
                end
                SQ_SETUP: begin
                    if (abort) begin
                        finish <= 1'b1;
                        state  <= SQ_IDLE;
                    end else if (done_s) begin
                        seen_low <= 1'b0;
                        state    <= SQ_PULSE;
                    end
                end
                SQ_PULSE: begin
                    if (!done_s) seen_low <= 1'b1;
                    if (abort)   abort_pend <= 1'b1;
                    if (release_ok) begin
                        remaining  <= remaining - 1'b1;
                        steps_done <= steps_done + 1'b1;
                        state      <= SQ_RECOVER;
                    end else if (time_out) begin
                        err    <= 1'b1;
                        finish <= 1'b1;
                        state  <= SQ_IDLE;
                    end
                end
                SQ_RECOVER: begin
                    if (abort) abort_pend <= 1'b1;
                    if (done_s) begin
                        if (remaining == '0 || abort_pend || abort) begin
                            finish <= 1'b1;
                            state  <= SQ_IDLE;
                        end else begin
                            seen_low <= 1'b0;
                            state    <= SQ_PULSE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R5: a normal release happens only after done was seen low in the pulse
    release_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_RECOVER && $past(state) == SQ_PULSE) |-> seen_low);

    // R7: each completed pulse advances the step counter by exactly one
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_RECOVER && $past(state) == SQ_PULSE) |-> (steps_done == $past(steps_done) + 1'b1));

    // R9: a timeout leaves the pulse without counting it
    timeout_nocount_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err)) |-> ($stable(steps_done) && state == SQ_IDLE));

endmodule

// File: rtl/phase_step_seq.sv
// Top of the PLL phase-step sequencer. Takes one command (counter select,
// direction, step count) and runs the PLL's step/done handshake once per
// step.
// Assumes: clk is the scan clock; pll_done is asynchronous and idles high;
// rst_n is synchronous to clk.
module phase_step_seq
    import phase_seq_pkg::*;
#(
    parameter int SEL_W       = 3,
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HOLD    = 2,
    parameter int TIMEOUT     = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [SEL_W-1:0] cmd_sel,
    input  logic             cmd_up,
    input  logic [CNT_W-1:0] cmd_steps,
    input  logic             abort,
    input  logic             pll_done,
    output logic             pll_step,
    output logic             pll_updn,
    output logic [SEL_W-1:0] pll_sel,
    output logic             busy,
    output logic             cmd_finish,
    output logic             err_timeout,
    output logic [CNT_W-1:0] steps_done
);

    seq_state_t state;
    logic       done_s;
    logic       hold_met;
    logic       expired;
    logic       in_pulse;

    seq_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pll_done),
        .q    (done_s)
    );

    strobe_timer #(
        .MIN_HOLD(MIN_HOLD),
        .TIMEOUT (TIMEOUT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_pulse),
        .hold_met(hold_met),
        .expired (expired)
    );

    seq_ctrl #(
        .SEL_W(SEL_W),
        .CNT_W(CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_sel   (cmd_sel),
        .cmd_up    (cmd_up),
        .cmd_steps (cmd_steps),
        .abort     (abort),
        .done_s    (done_s),
        .hold_met  (hold_met),
        .expired   (expired),
        .state     (state),
        .sel_q     (pll_sel),
        .up_q      (pll_updn),
        .steps_done(steps_done),
        .err       (err_timeout),
        .finish    (cmd_finish)
    );

    // Decode outward strobes from the sequencer phase
    assign in_pulse  = (state == SQ_PULSE);
    assign pll_step  = in_pulse;
    assign busy      = (state != SQ_IDLE);
    assign cmd_ready = (state == SQ_IDLE);

    // R4
    step_min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_step) |-> ($past(pll_step, 1) && $past(pll_step, 2)));

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(pll_sel) && $stable(pll_updn)));

    // R3
    step_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_step) |-> $past(done_s));

    // R1
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> ($stable(pll_sel) && $stable(pll_updn)));

    // R8
    zero_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_steps == '0) |=> (cmd_finish && !busy));

    // R11
    finish_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_finish |=> !cmd_finish);

endmodule

// File: tb/phase_step_seq_test.sv
// Self-checking bench: a randomised PLL done model plus directed corners.
module phase_step_seq_test;

    localparam int SEL_W = 3;
    localparam int CNT_W = 10;
    localparam int TMO   = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [SEL_W-1:0] cmd_sel = '0;
    logic             cmd_up = 1'b0;
    logic [CNT_W-1:0] cmd_steps = '0;
    logic             abort = 1'b0;
    logic             pll_done = 1'b1;
    logic             pll_step;
    logic             pll_updn;
    logic [SEL_W-1:0] pll_sel;
    logic             busy;
    logic             cmd_finish;
    logic             err_timeout;
    logic [CNT_W-1:0] steps_done;

    phase_step_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_sel    (cmd_sel),
        .cmd_up     (cmd_up),
        .cmd_steps  (cmd_steps),
        .abort      (abort),
        .pll_done   (pll_done),
        .pll_step   (pll_step),
        .pll_updn   (pll_updn),
        .pll_sel    (pll_sel),
        .busy       (busy),
        .cmd_finish (cmd_finish),
        .err_timeout(err_timeout),
        .steps_done (steps_done)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // monitor state
    int pulses, high_len, last_high, fin_cnt, busy_seen;
    int width_viol, early_viol, rise_low_viol, sel_viol;
    bit low_seen, prev_step;
    logic [SEL_W-1:0] exp_sel;
    logic             exp_up;
    // PLL model state
    int  mdl_phase, mdl_cnt, mdl_low;
    bit  stuck;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            chk(1'b0, "watchdog", cycles, 190000);
            finish_run();
        end
    end

    // Monitor first, then the PLL model, both away from the active edge
    always @(negedge clk) begin
        if (pll_step && !prev_step) begin
            pulses++;
            high_len = 1;
            low_seen = 1'b0;
            if (!pll_done) rise_low_viol++;
        end else if (pll_step) begin
            high_len++;
        end
        if (pll_step && !pll_done) low_seen = 1'b1;
        if (!pll_step && prev_step) begin
            if (high_len < 2) width_viol++;
            if (!low_seen) early_viol++;
            last_high = high_len;
        end
        if (busy) begin
            busy_seen++;
            if (pll_sel != exp_sel || pll_updn != exp_up) sel_viol++;
        end
        if (cmd_finish) fin_cnt++;
        prev_step = pll_step;

        case (mdl_phase)
            0: if (pll_step && !stuck) begin
                   mdl_cnt   = $urandom % 4;
                   mdl_low   = 1 + ($urandom % 6);
                   mdl_phase = 1;
               end
            1: if (mdl_cnt == 0) begin
                   pll_done  = 1'b0;
                   mdl_phase = 2;
               end else mdl_cnt--;
            2: begin
                   mdl_low--;
                   if (mdl_low <= 0) begin
                       pll_done  = 1'b1;
                       mdl_phase = 3;
                   end
               end
            default: if (!pll_step) mdl_phase = 0;
        endcase
    end

    function automatic int exp_rises(input int n, input int amode, input bit stk);
        if (n == 0 || amode == 2) return 0;
        if (stk || amode == 1) return 1;
        return n;
    endfunction

    function automatic int exp_count(input int n, input int amode, input bit stk);
        if (stk) return 0;
        return exp_rises(n, amode, stk);
    endfunction

    // amode: 0 none, 1 abort during first pulse, 2 abort right after acceptance
    task automatic run_cmd(input logic [SEL_W-1:0] s, input logic u, input int n,
                           input int amode, input bit stk, input bit intrude);
        int wait_cnt;
        @(negedge clk);
        pulses = 0; fin_cnt = 0; busy_seen = 0; width_viol = 0; early_viol = 0;
        rise_low_viol = 0; sel_viol = 0; last_high = 0;
        exp_sel = s; exp_up = u; stuck = stk;
        cmd_valid = 1'b1; cmd_sel = s; cmd_up = u; cmd_steps = CNT_W'(n);
        if (amode == 2) abort = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        abort = 1'b0;
        wait_cnt = 0;
        while (fin_cnt == 0 && wait_cnt < 60000) begin
            if (amode == 1 && pulses == 1 && pll_step && !abort) abort = 1'b1;
            else abort = 1'b0;
            if (intrude && pulses == 1 && wait_cnt < 40) begin
                cmd_valid = 1'b1; cmd_sel = ~s; cmd_up = ~u; cmd_steps = 10'd3;
            end else cmd_valid = 1'b0;
            @(negedge clk);
            wait_cnt++;
        end
        abort = 1'b0; cmd_valid = 1'b0;
        chk(busy == 1'b0 && cmd_ready == 1'b1, "R11 idle at finish", busy, 0);
        chk(err_timeout == stk, "R9 error flag", err_timeout, stk);
        repeat (12) @(negedge clk);
        chk(fin_cnt == 1, "R11 single finish", fin_cnt, 1);
        chk(pulses == exp_rises(n, amode, stk), "R7/R10 pulse count", pulses, exp_rises(n, amode, stk));
        chk(steps_done == CNT_W'(exp_count(n, amode, stk)), "R7 steps_done", steps_done, exp_count(n, amode, stk));
        chk(width_viol == 0, "R4 min hold", width_viol, 0);
        chk(rise_low_viol == 0, "R3/R6 rise on done high", rise_low_viol, 0);
        chk(sel_viol == 0, "R2/R1 select stable", sel_viol, 0);
        if (stk) chk(last_high == TMO, "R9 timeout width", last_high, TMO);
        else     chk(early_viol == 0, "R5 release after low", early_viol, 0);
        if (n == 0) chk(busy_seen == 0, "R8 zero never busy", busy_seen, 0);
        stuck = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        mdl_phase = 0; prev_step = 1'b0; stuck = 1'b0;
        exp_sel = '0; exp_up = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(cmd_ready && !busy && !pll_step && !cmd_finish && !err_timeout && steps_done == 0,
            "R12 reset state", {busy, pll_step, err_timeout}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: abort while idle is ignored
        abort = 1'b1;
        repeat (3) @(negedge clk);
        abort = 1'b0;
        chk(!busy && fin_cnt == 0, "R10 idle abort ignored", busy, 0);
        run_cmd(3'd2, 1'b1, 3, 0, 1'b0, 1'b0);
        run_cmd(3'd5, 1'b0, 0, 0, 1'b0, 1'b0);     // R8
        run_cmd(3'd1, 1'b1, 1, 0, 1'b0, 1'b0);
        run_cmd(3'd4, 1'b0, 5, 0, 1'b1, 1'b0);     // R9 stuck done
        run_cmd(3'd3, 1'b0, 4, 0, 1'b0, 1'b0);     // R9 error cleared next
        run_cmd(3'd6, 1'b1, 20, 1, 1'b0, 1'b0);    // R10 abort mid pulse
        run_cmd(3'd7, 1'b0, 9, 2, 1'b0, 1'b0);     // R10 abort at start
        run_cmd(3'd0, 1'b1, 5, 0, 1'b0, 1'b1);     // R1 offer while busy
        run_cmd(3'd2, 1'b0, 1023, 0, 1'b0, 1'b0);  // R7 full count
        for (int i = 0; i < 14; i++) begin
            run_cmd(SEL_W'($urandom), 1'($urandom), int'($urandom % 9), 0, 1'b0, 1'b0);
        end
        finish_run();
    end

endmodule